// File: doc/BRIEF.md
# DMA Request Boundary Splitter

This block sits in a DMA request generator and turns one transfer request, given as a start address, a byte count and a read/write direction, into a series of memory sub-requests. It accepts the request over a valid/ready handshake. It then hands out the sub-requests one at a time, in ascending address order, over a second valid/ready handshake. Each sub-request carries its address, its byte length, the direction and a flag that marks the final piece.

A requester may hand over a buffer that spans a 4 KB page boundary. Every sub-request that leaves the block already stays inside one page, so no stage further down has to cut anything. Sub-requests also follow 64-byte lines wherever the buffer permits. An unaligned start is first brought up to the next line boundary. The middle pieces are then capped at `MAX_PAYLOAD` bytes, a multiple of 64, and also at the page end. The final piece carries whatever bytes are left.

The controller has three states. `ST_IDLE` accepts a request. A non-zero length moves it to `ST_EMIT`, and a zero length moves it to `ST_REJECT`. `ST_EMIT` presents a sub-request and stays there after each hand-off that is not the last one. The hand-off of the last one returns it to `ST_IDLE`. `ST_REJECT` raises the error output for one cycle and then returns to `ST_IDLE`.

Top module: `dma_page_splitter`

## Requirements
- R1: After reset, sub_valid and req_err are 0 and req_ready is 1.
- R2: For every sub-request, (sub_addr mod 4096) + sub_len is at most 4096.
- R3: When the current address is not a multiple of 64, the sub-request length is the smaller of (64 - address mod 64) and the bytes remaining.
- R4: When the current address is a multiple of 64, the length is the smallest of MAX_PAYLOAD (default 128), the bytes left to the next 4096-byte boundary, and the bytes remaining.
- R5: The first sub-request starts at the request address. Each following sub-request starts at the previous address plus the previous length. The lengths add up to the request length.
- R6: sub_last is 1 on the final sub-request of a request and 0 on every other one.
- R7: req_ready is 0 from the cycle after a request is accepted until the cycle after its final sub-request is handed off. While sub_valid is 1, req_ready is 0.
- R8: While sub_valid is 1 and sub_ready is 0, the sub-request fields are held unchanged and sub_valid stays 1.
- R9: A request with length 0 is accepted. It produces no sub-request, and req_err is 1 for exactly the one cycle after acceptance.
- R10: sub_write equals the req_write value of the request (1 = write, 0 = read) on every one of its sub-requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 64 | Request start byte address |
| req_len | input | 16 | Request length in bytes |
| req_write | input | 1 | 1 = write, 0 = read |
| req_err | output | 1 | One-cycle pulse after a zero-length request |
| sub_valid | output | 1 | Sub-request offered |
| sub_ready | input | 1 | Consumer takes the sub-request |
| sub_addr | output | 64 | Sub-request start address |
| sub_len | output | 13 | Sub-request length in bytes |
| sub_write | output | 1 | Sub-request direction |
| sub_last | output | 1 | Final sub-request of the request |

## Verification
The bench goes after buffers that end exactly at a page end or one byte past it. It also drives unaligned starts a few bytes below a page boundary, one-byte and 64-byte requests, and the largest 16-bit length. A calculator that measured page room from the wrong offset would emit a piece that runs into the next page. A missing line alignment step would let an unaligned start run a full payload. The bench also holds sub_ready low on selected pieces. A design that advanced its cursor without a handshake would then lose or repeat a piece, and the address chain check would catch it. Zero-length requests are sent between normal ones. A design that let them through would emit an empty piece or fail to pulse req_err.

// File: rtl/split_pkg.sv
package split_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_EMIT   = 2'd1,
        ST_REJECT = 2'd2
    } split_state_e;

endpackage

// File: rtl/split_chunk_calc.sv
module split_chunk_calc #(
    parameter int LEN_W       = 16,
    parameter int PAGE_BYTES  = 4096,
    parameter int LINE_BYTES  = 64,
    parameter int MAX_PAYLOAD = 128,
    localparam int PAGE_W     = $clog2(PAGE_BYTES),
    localparam int LINE_W     = $clog2(LINE_BYTES),
    localparam int CH_W       = LEN_W + 1
) (
    input  logic [PAGE_W-1:0] page_off,
    input  logic [LEN_W-1:0]  remaining,
    output logic [CH_W-1:0]   chunk_len,
    output logic              is_last
);

    logic [CH_W-1:0] line_off;
    logic [CH_W-1:0] page_left;
    logic [CH_W-1:0] rem_ext;
    logic [CH_W-1:0] cap;

    assign line_off  = CH_W'(page_off[LINE_W-1:0]);
    assign page_left = CH_W'(PAGE_BYTES) - CH_W'(page_off);
    assign rem_ext   = CH_W'(remaining);

    always_comb begin
        if (line_off != '0) begin
            cap = CH_W'(LINE_BYTES) - line_off;
        end else if (page_left < CH_W'(MAX_PAYLOAD)) begin
            cap = page_left;
        end else begin
            cap = CH_W'(MAX_PAYLOAD);
        end
        chunk_len = (rem_ext < cap) ? rem_ext : cap;
        is_last   = (rem_ext <= cap);
    end

    initial begin
        a_cfg_payload_r4: assert (MAX_PAYLOAD % LINE_BYTES == 0 && MAX_PAYLOAD <= PAGE_BYTES);
        a_cfg_line_r2: assert (PAGE_BYTES % LINE_BYTES == 0 && CH_W > PAGE_W);
    end

endmodule

// File: rtl/split_cursor.sv
module split_cursor #(
    parameter int ADDR_W = 64,
    parameter int LEN_W  = 16,
    localparam int CH_W  = LEN_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [LEN_W-1:0]  load_len,
    input  logic              step,
    input  logic [CH_W-1:0]   step_len,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [LEN_W-1:0]  cur_rem
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr <= '0;
            cur_rem  <= '0;
        end else if (load) begin
            cur_addr <= load_addr;
            cur_rem  <= load_len;
        end else if (step) begin
            cur_addr <= cur_addr + ADDR_W'(step_len);
            cur_rem  <= cur_rem - LEN_W'(step_len);
        end
    end

    // R5: a step never consumes more than what is left, and advances the address by its size
    p_step_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        step && !load |-> CH_W'(cur_rem) >= step_len && step_len != '0);
    p_chain_r5: assert property (@(posedge clk) disable iff (!rst_n)
        step && !load |=> cur_addr == $past(cur_addr) + ADDR_W'($past(step_len)));

endmodule

// File: rtl/dma_page_splitter.sv
module dma_page_splitter
    import split_pkg::*;
#(
    parameter int ADDR_W      = 64,
    parameter int LEN_W       = 16,
    parameter int OLEN_W      = 13,
    parameter int PAGE_BYTES  = 4096,
    parameter int LINE_BYTES  = 64,
    parameter int MAX_PAYLOAD = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic              req_write,
    output logic              req_err,
    output logic              sub_valid,
    input  logic              sub_ready,
    output logic [ADDR_W-1:0] sub_addr,
    output logic [OLEN_W-1:0] sub_len,
    output logic              sub_write,
    output logic              sub_last
);

    localparam int PAGE_W = $clog2(PAGE_BYTES);
    localparam int LINE_W = $clog2(LINE_BYTES);
    localparam int CH_W   = LEN_W + 1;

    split_state_e state_q, state_d;

    logic              accept;
    logic              load;
    logic              step;
    logic              write_q;
    logic [ADDR_W-1:0] cur_addr;
    logic [LEN_W-1:0]  cur_rem;
    logic [CH_W-1:0]   chunk_len;
    logic              is_last;

    assign accept = req_valid && req_ready;
    assign load   = accept && (req_len != '0);
    assign step   = sub_valid && sub_ready;

    split_cursor #(
        .ADDR_W (ADDR_W),
        .LEN_W  (LEN_W)
    ) u_cursor (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_addr (req_addr),
        .load_len  (req_len),
        .step      (step),
        .step_len  (chunk_len),
        .cur_addr  (cur_addr),
        .cur_rem   (cur_rem)
    );

    split_chunk_calc #(
        .LEN_W       (LEN_W),
        .PAGE_BYTES  (PAGE_BYTES),
        .LINE_BYTES  (LINE_BYTES),
        .MAX_PAYLOAD (MAX_PAYLOAD)
    ) u_calc (
        .page_off  (cur_addr[PAGE_W-1:0]),
        .remaining (cur_rem),
        .chunk_len (chunk_len),
        .is_last   (is_last)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            write_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                write_q <= req_write;
            end
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    state_d = (req_len == '0) ? ST_REJECT : ST_EMIT;
                end
            end
            ST_EMIT: begin
                if (sub_ready && is_last) begin
                    state_d = ST_IDLE;
                end
            end
            ST_REJECT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_ready = 1'b0;
        req_err   = 1'b0;
        sub_valid = 1'b0;
        unique case (state_q)
            ST_IDLE:   req_ready = 1'b1;
            ST_EMIT:   sub_valid = 1'b1;
            ST_REJECT: req_err   = 1'b1;
            default:   req_ready = 1'b0;
        endcase
    end

    assign sub_addr  = cur_addr;
    assign sub_len   = OLEN_W'(chunk_len);
    assign sub_write = write_q;
    assign sub_last  = is_last;

    p_page_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sub_valid |-> (32'(sub_addr[PAGE_W-1:0]) + 32'(sub_len)) <= PAGE_BYTES);
    p_line_mult_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sub_valid && !sub_last && sub_addr[LINE_W-1:0] == '0 |-> sub_len[LINE_W-1:0] == '0);
    p_more_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sub_valid && sub_ready && !sub_last |=> sub_valid);
    p_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sub_valid && sub_ready && sub_last |=> !sub_valid && req_ready);
    p_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sub_valid |-> !req_ready);
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sub_valid && !sub_ready |=> sub_valid && $stable(sub_addr) && $stable(sub_len)
                                   && $stable(sub_last) && $stable(sub_write));
    p_err_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |=> !req_err);
    p_err_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |-> !sub_valid && !req_ready);
    p_nonempty_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sub_valid |-> sub_len != '0);

endmodule

// File: tb/tb_dma_page_splitter.sv
module tb_dma_page_splitter;

    localparam int MAXP = 128;

    typedef struct packed {
        logic [63:0] addr;
        logic [15:0] len;
        logic        wr;
        logic        stall;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{64'h0000_1000, 16'd256,   1'b1, 1'b0},
        '{64'h0000_1003, 16'd10,    1'b0, 1'b1},
        '{64'h0000_1003, 16'd200,   1'b1, 1'b1},
        '{64'h0000_0FC0, 16'd256,   1'b0, 1'b0},
        '{64'h0000_0FF0, 16'd32,    1'b1, 1'b1},
        '{64'hFFFF_FFFF_FFFF_EFA5, 16'd100, 1'b0, 1'b0},
        '{64'h0000_2000, 16'd1,     1'b1, 1'b0},
        '{64'h0000_3FFF, 16'd4098,  1'b0, 1'b1},
        '{64'h0000_5040, 16'd64,    1'b1, 1'b0},
        '{64'h0000_7F80, 16'd384,   1'b0, 1'b1},
        '{64'h0000_8F00, 16'd256,   1'b1, 1'b0},
        '{64'h0000_0000, 16'd65535, 1'b0, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [63:0] req_addr = '0;
    logic [15:0] req_len = '0;
    logic        req_write = 1'b0;
    logic        req_err;
    logic        sub_valid;
    logic        sub_ready = 1'b0;
    logic [63:0] sub_addr;
    logic [12:0] sub_len;
    logic        sub_write;
    logic        sub_last;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    dma_page_splitter dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_addr  (req_addr),
        .req_len   (req_len),
        .req_write (req_write),
        .req_err   (req_err),
        .sub_valid (sub_valid),
        .sub_ready (sub_ready),
        .sub_addr  (sub_addr),
        .sub_len   (sub_len),
        .sub_write (sub_write),
        .sub_last  (sub_last)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // expected piece length derived from R3/R4
    function automatic int exp_piece(input logic [63:0] a, input int rem);
        int lo, room, n;
        lo = int'(a % 64);
        if (lo != 0) begin
            n = 64 - lo;
        end else begin
            room = 4096 - int'(a % 4096);
            n = (room < MAXP) ? room : MAXP;
        end
        return (rem < n) ? rem : n;
    endfunction

    task automatic run_req(input vec_t v);
        logic [63:0] ea;
        int rem, n, guard, sum;
        bit held;
        ea = v.addr;
        rem = int'(v.len);
        sum = 0;
        @(negedge clk);
        check(req_ready == 1'b1, "R7 ready idle", longint'(req_ready), 1);
        req_valid = 1'b1;
        req_addr = v.addr;
        req_len = v.len;
        req_write = v.wr;
        @(negedge clk);
        req_valid = 1'b0;
        req_addr = '0;
        guard = 0;
        held = 1'b0;
        while (rem > 0 && guard < 2000) begin
            guard++;
            check(sub_valid == 1'b1, "R6 more pieces", longint'(sub_valid), 1);
            check(req_ready == 1'b0, "R7 busy", longint'(req_ready), 0);
            if (sub_valid !== 1'b1) break;
            n = exp_piece(ea, rem);
            check(sub_addr == ea, "R5 addr chain", longint'(sub_addr), longint'(ea));
            if (ea % 64 != 0)
                check(int'(sub_len) == n, "R3 unaligned len", longint'(sub_len), longint'(n));
            else
                check(int'(sub_len) == n, "R4 aligned len", longint'(sub_len), longint'(n));
            check(int'(sub_addr % 4096) + int'(sub_len) <= 4096, "R2 page cross",
                  longint'(int'(sub_addr % 4096) + int'(sub_len)), 4096);
            check(sub_last == (rem == n), "R6 last flag", longint'(sub_last), longint'(rem == n));
            check(sub_write == v.wr, "R10 direction", longint'(sub_write), longint'(v.wr));
            if (v.stall && !held) begin
                sub_ready = 1'b0;
                held = 1'b1;
                @(negedge clk);
                check(sub_valid && sub_addr == ea && int'(sub_len) == n,
                      "R8 hold under stall", longint'(sub_addr), longint'(ea));
            end
            sub_ready = 1'b1;
            @(negedge clk);
            sub_ready = 1'b0;
            held = 1'b0;
            ea = ea + 64'(n);
            rem = rem - n;
            sum = sum + n;
        end
        check(sum == int'(v.len), "R5 total bytes", longint'(sum), longint'(v.len));
        check(sub_valid == 1'b0 && req_ready == 1'b1, "R7 ready after last",
              longint'(req_ready), 1);
    endtask

    task automatic run_zero(input logic [63:0] a);
        @(negedge clk);
        req_valid = 1'b1;
        req_addr = a;
        req_len = '0;
        req_write = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check(req_err == 1'b1, "R9 error pulse", longint'(req_err), 1);
        check(sub_valid == 1'b0, "R9 no piece", longint'(sub_valid), 0);
        @(negedge clk);
        check(req_err == 1'b0, "R9 pulse width", longint'(req_err), 0);
        check(sub_valid == 1'b0 && req_ready == 1'b1, "R9 back to idle",
              longint'(req_ready), 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(sub_valid == 1'b0, "R1 reset valid", longint'(sub_valid), 0);
        check(req_ready == 1'b1, "R1 reset ready", longint'(req_ready), 1);
        check(req_err == 1'b0, "R1 reset err", longint'(req_err), 0);
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            run_req(VECS[i]);
        end
        // R9: zero length between ordinary requests, then a normal request still works
        run_zero(64'h0000_1234);
        run_req('{64'h0000_0FFF, 16'd2, 1'b1, 1'b1});
        run_zero(64'h0000_0000);
        // R8 with a piece at the page end held for several cycles
        run_req('{64'h0000_AFC0, 16'd65, 1'b0, 1'b1});
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule